// File: doc/BRIEF.md
# Instruction Class Decoder With Condition Gate

This block sorts a 32-bit instruction word into one of eighteen instruction classes and decides, from the four status flags, whether the word's condition allows it to run. It sits at the front of an execute stage. A downstream unit reads the one-hot class vector to choose its datapath, and reads the enable bit to decide whether to commit.

Each class has its own pattern over the opcode byte (bits 27:20), the low nibble group (bits 7:4) and, for a few classes, the middle bits. Several patterns overlap. An ordered priority picker resolves them, so that exactly one class wins. The condition nibble (bits 31:28) is checked against the flags in parallel with the class match. Both results are captured in one register stage, so the outputs describe the word that was presented on the previous rising edge.

Top module: `insn_class_gate`

## Requirements
- R1: After reset, class_o, cond_pass_o and exec_en_o are all zero. After every capture edge outside reset, exactly one bit of class_o is set. A bit with a lower index has priority over a bit with a higher index.
- R2: The condition nibble insn_i[31:28] is evaluated with flags_i[3]=N, flags_i[2]=Z, flags_i[1]=C and flags_i[0]=V. Codes 0 to 7 pass on Z, !Z, C, !C, N, !N, V and !V respectively.
- R3: Code 8 passes on C&!Z and code 9 on !C|Z. Code 10 passes on N==V and code 11 on N!=V. Code 12 passes on !Z&(N==V) and code 13 on Z|(N!=V). Code 14 always passes and code 15 never passes.
- R4: If bits 27:25 are 011 and bit 4 is set, the word is undefined (class bit 0). Any other word with bits 27:26 equal to 01 is a single load/store (class bit 1).
- R5: If bits 27:22 are zero and bits 7:4 are 1001, the word is a multiply (bit 2). If bits 27:23 are 00001 and bits 7:4 are 1001, it is a long multiply (bit 3). Both take priority over the halfword classes.
- R6: If bits 27:23 are 00010, bits 21:20 are 00 and bits 11:4 are 00001001, the word is a swap (bit 4). This ignores bit 22 and takes priority over the halfword classes.
- R7: If bits 27:25 are 000, bits 11:8 are zero, bit 7 is set and bit 4 is set, the word is a halfword transfer. Bit 22 clear selects the register-offset form (bit 5) and bit 22 set selects the immediate-offset form (bit 6).
- R8: Bits 27:25 equal to 100 give a block transfer (bit 7). Bits 27:25 equal to 110 give a coprocessor transfer (bit 8). Bits 27:24 equal to 1010 give a branch (bit 12), and 1011 give a branch with link (bit 13).
- R9: If bits 27:24 are 1110, the word is a coprocessor operation (bit 9) when bit 4 is clear and a coprocessor register move (bit 10) when bit 4 is set. Bits 27:24 equal to 1111 give a software trap (bit 11).
- R10: If bits 27:20 are 00010010, bits 19:8 are all ones and bits 7:4 are 0001, the word is a branch-exchange (bit 14). This outranks the status write. If any of bits 19:8 is clear, the word falls to a lower class.
- R11: If bits 27:23 are 00010, bits 21:20 are 00 and bits 11:0 are zero, the word is a status read (bit 15). If bits 27:26 are 00, bits 24:23 are 10 and bits 21:20 are 10, it is a status write (bit 16).
- R12: Any word with bits 27:26 equal to 00 that matches nothing above is a data-processing operation (bit 17). This class has the lowest priority.
- R13: exec_en_o equals cond_pass_o. When the condition fails, class_o still carries the decoded class. Every output reflects the inputs sampled on the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_i | input | 32 | Instruction word to classify |
| flags_i | input | 4 | Status flags: bit 3 N, bit 2 Z, bit 1 C, bit 0 V |
| class_o | output | 18 | Registered one-hot instruction class |
| cond_pass_o | output | 1 | Registered result of the condition check |
| exec_en_o | output | 1 | Registered execute enable, set when the condition passes |

## Verification
The only state is the output register, so a fault can show at the ports exactly one cycle after the word that exposes it. A broken priority link shows up as either two class bits set or the wrong surviving bit, but only for words that fall in two overlapping patterns. Examples are multiply against halfword, swap against halfword, and branch-exchange against status write. For this reason, directed words aim at each such overlap, and template-biased random words fill in the rest. A swapped condition polarity shows up only for some flag combinations, so the sixteen codes are swept against all sixteen flag values.

// File: rtl/icd_pkg.sv
`timescale 1ns/1ps
package icd_pkg;

  localparam int WORD_W = 32;
  localparam int CODE_W = 4;
  localparam int BODY_W = WORD_W - CODE_W;
  localparam int FLAG_W = 4;

  // flag positions inside flags_i
  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_C = 1;
  localparam int FL_V = 0;

  // class index doubles as priority rank: lower index wins
  typedef enum logic [4:0] {
    CL_UNDEF  = 5'd0,
    CL_XFER   = 5'd1,
    CL_MUL    = 5'd2,
    CL_MULL   = 5'd3,
    CL_SWAP   = 5'd4,
    CL_HREG   = 5'd5,
    CL_HIMM   = 5'd6,
    CL_BLOCK  = 5'd7,
    CL_CPXFER = 5'd8,
    CL_CPOP   = 5'd9,
    CL_CPREG  = 5'd10,
    CL_TRAP   = 5'd11,
    CL_BR     = 5'd12,
    CL_BRL    = 5'd13,
    CL_BX     = 5'd14,
    CL_SRRD   = 5'd15,
    CL_SRWR   = 5'd16,
    CL_ALU    = 5'd17
  } icls_e;

  localparam int NCLS = 18;

  // Codes come in pairs: the odd member is the inverse of the even one.
  // Pair 7 (codes 14/15) has a base of one, so 15 never passes.
  function automatic logic cond_ok(input logic [CODE_W-1:0] code,
                                   input logic [FLAG_W-1:0] f);
    logic n, z, c, v, base;
    n = f[FL_N];
    z = f[FL_Z];
    c = f[FL_C];
    v = f[FL_V];
    case (code[CODE_W-1:1])
      3'd0:    base = z;
      3'd1:    base = c;
      3'd2:    base = n;
      3'd3:    base = v;
      3'd4:    base = c & ~z;
      3'd5:    base = ~(n ^ v);
      3'd6:    base = ~z & ~(n ^ v);
      default: base = 1'b1;
    endcase
    return base ^ code[0];
  endfunction

endpackage

// File: rtl/icd_cond_eval.sv
`timescale 1ns/1ps
module icd_cond_eval
  import icd_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              pass_o
);

  assign pass_o = cond_ok(code_i, flags_i);

endmodule

// File: rtl/icd_class_match.sv
`timescale 1ns/1ps
module icd_class_match
  import icd_pkg::*;
(
  input  logic [BODY_W-1:0] body_i,
  output logic [NCLS-1:0]   hit_o
);

  logic [2:0] top3;
  logic [3:0] top4;
  logic [7:0] opbyte;
  logic [3:0] tail;
  logic       mul_tail;
  logic       half_shape;
  logic       sr_shape;

  assign top3       = body_i[27:25];
  assign top4       = body_i[27:24];
  assign opbyte     = body_i[27:20];
  assign tail       = body_i[7:4];
  assign mul_tail   = (tail == 4'b1001);
  assign half_shape = (top3 == 3'b000) && (body_i[11:8] == 4'h0)
                      && body_i[7] && body_i[4];
  assign sr_shape   = (body_i[27:23] == 5'b00010) && (body_i[21:20] == 2'b00);

  // raw matches; overlaps are resolved later by the priority picker
  always_comb begin
    hit_o            = '0;
    hit_o[CL_UNDEF]  = (top3 == 3'b011) && body_i[4];
    hit_o[CL_XFER]   = (body_i[27:26] == 2'b01);
    hit_o[CL_MUL]    = (body_i[27:22] == 6'b000000) && mul_tail;
    hit_o[CL_MULL]   = (body_i[27:23] == 5'b00001) && mul_tail;
    hit_o[CL_SWAP]   = sr_shape && (body_i[11:4] == 8'b0000_1001);
    hit_o[CL_HREG]   = half_shape && !body_i[22];
    hit_o[CL_HIMM]   = half_shape && body_i[22];
    hit_o[CL_BLOCK]  = (top3 == 3'b100);
    hit_o[CL_CPXFER] = (top3 == 3'b110);
    hit_o[CL_CPOP]   = (top4 == 4'b1110) && !body_i[4];
    hit_o[CL_CPREG]  = (top4 == 4'b1110) && body_i[4];
    hit_o[CL_TRAP]   = (top4 == 4'b1111);
    hit_o[CL_BR]     = (top4 == 4'b1010);
    hit_o[CL_BRL]    = (top4 == 4'b1011);
    hit_o[CL_BX]     = (opbyte == 8'b0001_0010) && (&body_i[19:8])
                       && (tail == 4'b0001);
    hit_o[CL_SRRD]   = sr_shape && (body_i[11:0] == 12'h000);
    hit_o[CL_SRWR]   = (body_i[27:26] == 2'b00) && (body_i[24:23] == 2'b10)
                       && (body_i[21:20] == 2'b10);
    hit_o[CL_ALU]    = (body_i[27:26] == 2'b00);
  end

endmodule

// File: rtl/icd_prio_pick.sv
`timescale 1ns/1ps
module icd_prio_pick #(
  parameter int W = 18
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] gnt_o
);

  // seen[i]: some request with a lower index (higher priority) is active
  logic [W-1:0] seen;

  assign seen[0] = 1'b0;
  for (genvar i = 1; i < W; i++) begin : g_chain
    assign seen[i] = seen[i-1] | req_i[i-1];
  end

  assign gnt_o = req_i & ~seen;

endmodule

// File: rtl/insn_class_gate.sv
`timescale 1ns/1ps
module insn_class_gate
  import icd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] insn_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [NCLS-1:0]   class_o,
  output logic              cond_pass_o,
  output logic              exec_en_o
);

  logic [NCLS-1:0] match_vec;
  logic [NCLS-1:0] pick_vec;
  logic            pass_d;

  icd_class_match u_match (
    .body_i (insn_i[BODY_W-1:0]),
    .hit_o  (match_vec)
  );

  icd_prio_pick #(.W(NCLS)) u_pick (
    .req_i (match_vec),
    .gnt_o (pick_vec)
  );

  icd_cond_eval u_cond (
    .code_i  (insn_i[WORD_W-1:BODY_W]),
    .flags_i (flags_i),
    .pass_o  (pass_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      class_o     <= '0;
      cond_pass_o <= 1'b0;
      exec_en_o   <= 1'b0;
    end else begin
      class_o     <= pick_vec;
      cond_pass_o <= pass_d;
      exec_en_o   <= pass_d;
    end
  end

endmodule

// File: rtl/icd_checker.sv
`timescale 1ns/1ps
module icd_checker
  import icd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] insn_i,
  input logic [NCLS-1:0]   class_o,
  input logic              cond_pass_o,
  input logic              exec_en_o,
  input logic [NCLS-1:0]   match_vec,
  input logic [NCLS-1:0]   pick_vec,
  input logic              pass_d
);

  // R1: a capture outside reset always yields one class
  a_r1_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $onehot(class_o));

  // R1: the picker grants only a raw match
  a_r1_grant_subset: assert property (@(posedge clk) disable iff (!rst_n)
    ((pick_vec & ~match_vec) == '0));

  // R3: code 14 always passes
  a_r3_always: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && insn_i[31:28] == 4'hE) |=> cond_pass_o);

  // R3: code 15 never passes
  a_r3_never: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && insn_i[31:28] == 4'hF) |=> !cond_pass_o);

  // R8: branch with link
  a_r8_link: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && insn_i[27:24] == 4'hB) |=> class_o[CL_BRL]);

  // R10: branch-exchange wins over the status write
  a_r10_bx: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && insn_i[27:4] == 24'h12FFF1) |=> class_o[CL_BX]);

  // R11: status read shape
  a_r11_srrd: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && insn_i[27:23] == 5'b00010 && insn_i[21:20] == 2'b00
     && insn_i[11:0] == 12'h000) |=> class_o[CL_SRRD]);

  // R13: failing condition drops enable but keeps a class
  a_r13_fail_keeps_class: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !pass_d) |=> (!exec_en_o && $onehot(class_o)));

  // R13: enable and pass bit agree
  a_r13_enable_match: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en_o == cond_pass_o);

endmodule

bind insn_class_gate icd_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .insn_i      (insn_i),
  .class_o     (class_o),
  .cond_pass_o (cond_pass_o),
  .exec_en_o   (exec_en_o),
  .match_vec   (match_vec),
  .pick_vec    (pick_vec),
  .pass_d      (pass_d)
);

// File: tb/sim_insn_class_gate.sv
`timescale 1ns/1ps
module sim_insn_class_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn = 32'h0;
  logic [3:0]  flags = 4'h0;
  logic [17:0] cls;
  logic        cp;
  logic        ee;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  insn_class_gate u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_i      (insn),
    .flags_i     (flags),
    .class_o     (cls),
    .cond_pass_o (cp),
    .exec_en_o   (ee)
  );

  // class templates in priority order (mask, value)
  function automatic logic [31:0] pat_mask(input int k);
    case (k)
      0:  return 32'h0E000010;
      1:  return 32'h0C000000;
      2:  return 32'h0FC000F0;
      3:  return 32'h0F8000F0;
      4:  return 32'h0FB00FF0;
      5:  return 32'h0E400F90;
      6:  return 32'h0E400F90;
      7:  return 32'h0E000000;
      8:  return 32'h0E000000;
      9:  return 32'h0F000010;
      10: return 32'h0F000010;
      11: return 32'h0F000000;
      12: return 32'h0F000000;
      13: return 32'h0F000000;
      14: return 32'h0FFFFFF0;
      15: return 32'h0FB00FFF;
      16: return 32'h0DB00000;
      default: return 32'h0C000000;
    endcase
  endfunction

  function automatic logic [31:0] pat_val(input int k);
    case (k)
      0:  return 32'h06000010;
      1:  return 32'h04000000;
      2:  return 32'h00000090;
      3:  return 32'h00800090;
      4:  return 32'h01000090;
      5:  return 32'h00000090;
      6:  return 32'h00400090;
      7:  return 32'h08000000;
      8:  return 32'h0C000000;
      9:  return 32'h0E000000;
      10: return 32'h0E000010;
      11: return 32'h0F000000;
      12: return 32'h0A000000;
      13: return 32'h0B000000;
      14: return 32'h012FFF10;
      15: return 32'h01000000;
      16: return 32'h01200000;
      default: return 32'h00000000;
    endcase
  endfunction

  function automatic int exp_class(input logic [31:0] w);
    for (int k = 0; k < 18; k++)
      if ((w & pat_mask(k)) == pat_val(k)) return k;
    return -1;
  endfunction

  function automatic logic exp_cond(input logic [3:0] code, input logic [3:0] f);
    logic n, z, c, v;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (code)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input int k);
    case (k)
      0, 1:           return "R4";
      2, 3:           return "R5";
      4:              return "R6";
      5, 6:           return "R7";
      7, 8, 12, 13:   return "R8";
      9, 10, 11:      return "R9";
      14:             return "R10";
      15, 16:         return "R11";
      default:        return "R12";
    endcase
  endfunction

  task automatic run_one(input logic [31:0] w, input logic [3:0] f);
    int          ei;
    logic [17:0] ec;
    logic        ep;
    @(negedge clk);
    insn  = w;
    flags = f;
    @(negedge clk);
    ei = exp_class(w);
    ec = (ei < 0) ? 18'h0 : (18'd1 << ei);
    ep = exp_cond(w[31:28], f);
    checks++;
    if ($countones(cls) != 1) begin
      errors++;
      $display("FAIL R1 one-hot insn=%h got %b exp one bit set", w, cls);
    end
    checks++;
    if (cls !== ec) begin
      errors++;
      $display("FAIL %s class insn=%h got %b exp %b", req_of(ei), w, cls, ec);
    end
    checks++;
    if (cp !== ep) begin
      errors++;
      $display("FAIL %s cond insn=%h flags=%b got %b exp %b",
               (w[31:28] < 4'd8) ? "R2" : "R3", w, f, cp, ep);
    end
    checks++;
    if (ee !== ep) begin
      errors++;
      $display("FAIL R13 enable insn=%h flags=%b got %b exp %b", w, f, ee, ep);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rw;
    int          rk;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (cls !== 18'h0 || cp !== 1'b0 || ee !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset got %b/%b/%b exp 0/0/0", cls, cp, ee);
    end
    rst_n = 1'b1;

    // directed class examples and overlaps
    run_one(32'hE6000010, 4'h0); // R4 undefined
    run_one(32'hE6000000, 4'h0); // R4 transfer, bit 4 clear
    run_one(32'hE0000090, 4'h0); // R5 multiply beats halfword
    run_one(32'hE0800090, 4'h0); // R5 long multiply
    run_one(32'hE1000090, 4'h0); // R6 swap beats halfword
    run_one(32'hE1400090, 4'h0); // R6 swap with bit 22 set
    run_one(32'hE00000B0, 4'h0); // R7 register offset
    run_one(32'hE04000B0, 4'h0); // R7 immediate offset
    run_one(32'hE01000F0, 4'h0); // R7 register offset, other tail
    run_one(32'hE8000000, 4'h0); // R8 block
    run_one(32'hEC000000, 4'h0); // R8 coprocessor transfer
    run_one(32'hEA000000, 4'h0); // R8 branch
    run_one(32'hEB000000, 4'h0); // R8 branch with link
    run_one(32'hEE000000, 4'h0); // R9 coprocessor op
    run_one(32'hEE000010, 4'h0); // R9 coprocessor register
    run_one(32'hEF000000, 4'h0); // R9 trap
    run_one(32'hE12FFF10, 4'h0); // R10 branch-exchange
    run_one(32'hE12FFE10, 4'h0); // R10 one middle bit clear -> status write
    run_one(32'hE10F0000, 4'h0); // R11 status read
    run_one(32'hE10F0001, 4'h0); // R11 low bit set -> data processing
    run_one(32'hE3200000, 4'h0); // R11 status write, immediate
    run_one(32'hE0000000, 4'h0); // R12 data processing
    run_one(32'hE3A00000, 4'h0); // R12 data processing, immediate
    run_one(32'hF0000090, 4'h0); // R13 never-code, class still driven

    // R2/R3 condition sweep over every flag value
    for (int code = 0; code < 16; code++)
      for (int f = 0; f < 16; f++)
        run_one({code[3:0], 28'h1A00000 + 28'(f)}, f[3:0]);

    // template-biased random words
    for (int i = 0; i < 3000; i++) begin
      rk = $urandom_range(0, 17);
      rw = ($urandom & ~pat_mask(rk)) | pat_val(rk);
      run_one(rw, 4'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule